// File: doc/BRIEF.md
# Serial Flash Status and Write-Enable Control

This block keeps the status byte of a small serial flash memory. A command decoder in front of it turns each incoming command into a one-cycle strobe: set write enable, clear write enable, status write with a data byte, single-byte program, auto-increment program, and erase of a sector, a block or the whole array. The block answers with the status byte for read-back, a write-permitted flag and a busy flag.

Program and erase times are modelled by a down-counter. Each operation type loads its own cycle count from a parameter. The write-enable latch guards every array operation. It drops by itself once the operation finishes, with one exception: a word inside an auto-increment run that is not the last word. A lock bit freezes the two protection-level bits. Reserved bits always read 0. While the block is busy, every strobe is dropped and is reported on a one-cycle flag. Reading the status byte needs no strobe, so polling works at any time.

Top module: `flash_status_ctrl`

## Requirements
- R1: After the active-low asynchronous reset, `status_o` is 8'h0C (bits 3 and 2 set, all others 0), and `write_ok_o`, `busy_o` and `cmd_dropped_o` are 0.
- R2: A `wr_en_i` strobe while idle sets the write-enable bit (status bit 1, also `write_ok_o`) from the next cycle.
- R3: A `wr_dis_i` strobe while idle clears the write-enable bit and ends auto-increment mode (status bit 6) from the next cycle.
- R4: A program or erase strobe while the write-enable bit is 0 has no effect. Busy stays 0 and the status byte is unchanged.
- R5: A program or erase strobe accepted while idle and write-enabled raises busy (`busy_o` and status bit 0) from the next cycle for exactly the parameter count of that operation: T_PROG_BYTE, T_PROG_AUTO, T_ERASE_SEC, T_ERASE_BLK or T_ERASE_ALL.
- R6: When a byte program or an erase finishes, the write-enable bit clears on the same edge where busy falls.
- R7: An accepted `prog_auto_i` sets status bit 6. When the word finishes, write enable and bit 6 both stay set, unless `auto_last_i` was high with that strobe. In that case both clear as busy falls.
- R8: A `stat_wr_i` strobe while idle loads status bit 7 (lock) from data bit 7. It loads bits 3:2 from data bits 3:2 only if the lock was 0 before the write. Bits 0, 1, 4, 5 and 6 are not changed by the data.
- R9: Any strobe that arrives while busy is dropped. The lock and protection bits stay unchanged, and `cmd_dropped_o` is high for exactly the following cycle.
- R10: When several strobes coincide, only the highest-priority one acts. The order from highest to lowest is erase-all, erase-block, erase-sector, auto program, byte program, status write, clear enable, set enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Set write-enable strobe |
| wr_dis_i | input | 1 | Clear write-enable strobe |
| stat_wr_i | input | 1 | Status write strobe |
| stat_data_i | input | 8 | Status write data |
| prog_byte_i | input | 1 | Single-byte program strobe |
| prog_auto_i | input | 1 | Auto-increment program word strobe |
| auto_last_i | input | 1 | Marks the auto word as the top address |
| erase_sec_i | input | 1 | Sector erase strobe |
| erase_blk_i | input | 1 | Block erase strobe |
| erase_all_i | input | 1 | Whole-array erase strobe |
| status_o | output | 8 | Status byte |
| write_ok_o | output | 1 | Write-enable latch |
| busy_o | output | 1 | Operation in progress |
| cmd_dropped_o | output | 1 | A strobe was dropped while busy (one cycle) |

## Verification
The hardest case to reach is a strobe landing on the very edge where busy falls. On that edge the drop logic and the completion clearing act together. The stimulus issues strobes at chosen offsets inside each busy window, including the final busy cycle. It also runs an auto-increment series of several words before the last-word marker, so that the exemption from clearing is exercised across completions. A behavioural model in the bench tracks every output on each cycle.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned BIT_BUSY = 0;
  localparam int unsigned BIT_WEL  = 1;
  localparam int unsigned BIT_AAI  = 6;
  localparam int unsigned BIT_LOCK = 7;
  localparam logic [STAT_W-1:0] STAT_RST  = 8'h0C;
  // bits held in the writable protection register
  localparam logic [STAT_W-1:0] PROT_MASK = 8'h8C;
  localparam logic [STAT_W-1:0] LEVEL_MASK = 8'h0C;
  localparam logic [STAT_W-1:0] LOCK_MASK  = 8'h80;

  localparam int unsigned N_CMD = 8;

  // numeric order is priority, higher wins
  typedef enum logic [3:0] {
    CMD_NONE      = 4'd0,
    CMD_SET_WE    = 4'd1,
    CMD_CLR_WE    = 4'd2,
    CMD_STAT_WR   = 4'd3,
    CMD_PROG_BYTE = 4'd4,
    CMD_PROG_AUTO = 4'd5,
    CMD_ERASE_SEC = 4'd6,
    CMD_ERASE_BLK = 4'd7,
    CMD_ERASE_ALL = 4'd8
  } cmd_e;

  function automatic logic is_array_op(cmd_e c);
    return c inside {CMD_PROG_BYTE, CMD_PROG_AUTO, CMD_ERASE_SEC,
                     CMD_ERASE_BLK, CMD_ERASE_ALL};
  endfunction
endpackage

// File: rtl/flash_cmd_arbiter.sv
module flash_cmd_arbiter
  import flash_status_pkg::*;
(
  input  logic [N_CMD:1] req_i,
  output cmd_e           sel_o,
  output logic           any_o
);
  always_comb begin
    sel_o = CMD_NONE;
    for (int i = 1; i <= int'(N_CMD); i++) begin
      if (req_i[i]) sel_o = cmd_e'(4'(i));
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
  import flash_status_pkg::*;
#(
  parameter int unsigned T_PROG_BYTE = 4,
  parameter int unsigned T_PROG_AUTO = 3,
  parameter int unsigned T_ERASE_SEC = 20,
  parameter int unsigned T_ERASE_BLK = 40,
  parameter int unsigned T_ERASE_ALL = 80,
  localparam int unsigned T_MAX = (T_ERASE_ALL > T_ERASE_BLK) ?
                                  ((T_ERASE_ALL > T_ERASE_SEC) ? T_ERASE_ALL : T_ERASE_SEC) :
                                  ((T_ERASE_BLK > T_ERASE_SEC) ? T_ERASE_BLK : T_ERASE_SEC),
  localparam int unsigned T_TOP = (T_MAX > T_PROG_BYTE && T_MAX > T_PROG_AUTO) ? T_MAX :
                                  ((T_PROG_BYTE > T_PROG_AUTO) ? T_PROG_BYTE : T_PROG_AUTO),
  localparam int unsigned CNT_W = $clog2(T_TOP + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  cmd_e op_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    unique case (op_i)
      CMD_PROG_AUTO: load_val = CNT_W'(T_PROG_AUTO);
      CMD_ERASE_SEC: load_val = CNT_W'(T_ERASE_SEC);
      CMD_ERASE_BLK: load_val = CNT_W'(T_ERASE_BLK);
      CMD_ERASE_ALL: load_val = CNT_W'(T_ERASE_ALL);
      default:       load_val = CNT_W'(T_PROG_BYTE);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i)           cnt_q <= load_val;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/flash_status_regs.sv
module flash_status_regs
  import flash_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  input  logic              done_i,
  input  cmd_e              sel_i,
  input  logic [STAT_W-1:0] data_i,
  input  logic              auto_last_i,
  output logic              wel_o,
  output logic              aai_o,
  output logic [STAT_W-1:0] prot_o
);
  logic              wel_q, aai_q, auto_op_q, last_q;
  logic [STAT_W-1:0] prot_q, wr_mask;

  // level bits writable only while unlocked; lock always writable
  assign wr_mask = prot_q[BIT_LOCK] ? LOCK_MASK : (LOCK_MASK | LEVEL_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q     <= 1'b0;
      aai_q     <= 1'b0;
      auto_op_q <= 1'b0;
      last_q    <= 1'b0;
      prot_q    <= STAT_RST & PROT_MASK;
    end else if (done_i) begin
      if (!(auto_op_q && !last_q)) begin
        wel_q <= 1'b0;
        aai_q <= 1'b0;
      end
    end else if (idle_i) begin
      unique case (sel_i)
        CMD_SET_WE: wel_q <= 1'b1;
        CMD_CLR_WE: begin
          wel_q <= 1'b0;
          aai_q <= 1'b0;
        end
        CMD_STAT_WR: prot_q <= (prot_q & ~wr_mask) | (data_i & wr_mask);
        CMD_PROG_BYTE, CMD_PROG_AUTO, CMD_ERASE_SEC, CMD_ERASE_BLK, CMD_ERASE_ALL: begin
          if (wel_q) begin
            auto_op_q <= (sel_i == CMD_PROG_AUTO);
            last_q    <= auto_last_i;
            if (sel_i == CMD_PROG_AUTO) aai_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign wel_o  = wel_q;
  assign aai_o  = aai_q;
  assign prot_o = prot_q & PROT_MASK;
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
#(
  parameter int unsigned T_PROG_BYTE = 4,
  parameter int unsigned T_PROG_AUTO = 3,
  parameter int unsigned T_ERASE_SEC = 20,
  parameter int unsigned T_ERASE_BLK = 40,
  parameter int unsigned T_ERASE_ALL = 80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_dis_i,
  input  logic       stat_wr_i,
  input  logic [7:0] stat_data_i,
  input  logic       prog_byte_i,
  input  logic       prog_auto_i,
  input  logic       auto_last_i,
  input  logic       erase_sec_i,
  input  logic       erase_blk_i,
  input  logic       erase_all_i,
  output logic [7:0] status_o,
  output logic       write_ok_o,
  output logic       busy_o,
  output logic       cmd_dropped_o
);
  logic [N_CMD:1]    req;
  cmd_e              sel;
  logic              any_req, busy, done, start, wel, aai, drop_q;
  logic [STAT_W-1:0] prot;

  assign req = {erase_all_i, erase_blk_i, erase_sec_i, prog_auto_i,
                prog_byte_i, stat_wr_i, wr_dis_i, wr_en_i};

  flash_cmd_arbiter u_arb (
    .req_i (req),
    .sel_o (sel),
    .any_o (any_req)
  );

  assign start = !busy && wel && is_array_op(sel);

  flash_op_timer #(
    .T_PROG_BYTE (T_PROG_BYTE),
    .T_PROG_AUTO (T_PROG_AUTO),
    .T_ERASE_SEC (T_ERASE_SEC),
    .T_ERASE_BLK (T_ERASE_BLK),
    .T_ERASE_ALL (T_ERASE_ALL)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .op_i    (sel),
    .busy_o  (busy),
    .done_o  (done)
  );

  flash_status_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idle_i      (!busy),
    .done_i      (done),
    .sel_i       (sel),
    .data_i      (stat_data_i),
    .auto_last_i (auto_last_i),
    .wel_o       (wel),
    .aai_o       (aai),
    .prot_o      (prot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drop_q <= 1'b0;
    else         drop_q <= busy && any_req;
  end

  always_comb begin
    status_o           = prot;
    status_o[BIT_BUSY] = busy;
    status_o[BIT_WEL]  = wel;
    status_o[BIT_AAI]  = aai;
  end

  assign write_ok_o    = wel;
  assign busy_o        = busy;
  assign cmd_dropped_o = drop_q;
endmodule

// File: rtl/flash_status_checker.sv
module flash_status_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       wr_dis_i,
  input logic       stat_wr_i,
  input logic       prog_byte_i,
  input logic       prog_auto_i,
  input logic       erase_sec_i,
  input logic       erase_blk_i,
  input logic       erase_all_i,
  input logic [7:0] status_o,
  input logic       write_ok_o,
  input logic       busy_o,
  input logic       cmd_dropped_o
);
  logic arr, any;
  assign arr = prog_byte_i | prog_auto_i | erase_sec_i | erase_blk_i | erase_all_i;
  assign any = arr | wr_en_i | wr_dis_i | stat_wr_i;

  p_set_we_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && wr_en_i && !wr_dis_i && !stat_wr_i && !arr) |=> write_ok_o);

  p_clr_we_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && wr_dis_i && !stat_wr_i && !arr) |=> (!write_ok_o && !status_o[6]));

  p_reject_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !write_ok_o && arr) |=> !busy_o);

  p_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && write_ok_o && arr) |=> busy_o);

  p_done_we_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !status_o[6]) |-> !write_ok_o);

  p_auto_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && write_ok_o && prog_auto_i && !erase_sec_i && !erase_blk_i && !erase_all_i)
      |=> status_o[6]);

  p_lock_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7] |=> $stable(status_o[3:2]));

  p_drop_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && any) |=> cmd_dropped_o);

  p_drop_state_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stat_wr_i) |=> ($stable(status_o[7]) && $stable(status_o[3:2])));

  p_drop_only_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !cmd_dropped_o);
endmodule

bind flash_status_ctrl flash_status_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_dis_i      (wr_dis_i),
  .stat_wr_i     (stat_wr_i),
  .prog_byte_i   (prog_byte_i),
  .prog_auto_i   (prog_auto_i),
  .erase_sec_i   (erase_sec_i),
  .erase_blk_i   (erase_blk_i),
  .erase_all_i   (erase_all_i),
  .status_o      (status_o),
  .write_ok_o    (write_ok_o),
  .busy_o        (busy_o),
  .cmd_dropped_o (cmd_dropped_o)
);

// File: tb/tb_flash_status_ctrl.sv
module tb_flash_status_ctrl;
  localparam int T_PB = 3, T_PA = 2, T_ES = 5, T_EB = 7, T_EA = 9;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 0, wr_dis_i = 0, stat_wr_i = 0, prog_byte_i = 0, prog_auto_i = 0;
  logic auto_last_i = 0, erase_sec_i = 0, erase_blk_i = 0, erase_all_i = 0;
  logic [7:0] stat_data_i = 8'h00;
  logic [7:0] status_o;
  logic write_ok_o, busy_o, cmd_dropped_o;

  always #2 clk_i = ~clk_i;

  flash_status_ctrl #(.T_PROG_BYTE(T_PB), .T_PROG_AUTO(T_PA), .T_ERASE_SEC(T_ES),
                      .T_ERASE_BLK(T_EB), .T_ERASE_ALL(T_EA)) dut (.*);

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_cnt;
  bit m_wel, m_aai, m_lock, m_auto, m_last, m_drop;
  bit [1:0] m_lvl;

  task automatic m_begin(int t, bit is_auto);
    if (m_wel) begin
      m_cnt = t; m_auto = is_auto; m_last = auto_last_i;
      if (is_auto) m_aai = 1;
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_wel = 0; m_aai = 0; m_lock = 0; m_lvl = 2'b11;
      m_auto = 0; m_last = 0; m_drop = 0;
    end else begin
      bit any;
      any = wr_en_i | wr_dis_i | stat_wr_i | prog_byte_i | prog_auto_i |
            erase_sec_i | erase_blk_i | erase_all_i;
      m_drop = 0;
      if (m_cnt > 0) begin
        m_drop = any;
        m_cnt--;
        if (m_cnt == 0 && !(m_auto && !m_last)) begin m_wel = 0; m_aai = 0; end
      end
      else if (erase_all_i) m_begin(T_EA, 0);
      else if (erase_blk_i) m_begin(T_EB, 0);
      else if (erase_sec_i) m_begin(T_ES, 0);
      else if (prog_auto_i) m_begin(T_PA, 1);
      else if (prog_byte_i) m_begin(T_PB, 0);
      else if (stat_wr_i) begin
        if (!m_lock) m_lvl = stat_data_i[3:2];
        m_lock = stat_data_i[7];
      end
      else if (wr_dis_i) begin m_wel = 0; m_aai = 0; end
      else if (wr_en_i) m_wel = 1;
    end
  end

  always @(negedge clk_i) if (rst_ni) begin
    check(cur_req, status_o, {m_lock, m_aai, 2'b00, m_lvl, m_wel, m_cnt > 0});
    check(cur_req, {7'd0, write_ok_o}, {7'd0, m_wel});
    check(cur_req, {7'd0, busy_o}, {7'd0, m_cnt > 0});
    check(cur_req, {7'd0, cmd_dropped_o}, {7'd0, m_drop});
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic clr;
    wr_en_i = 0; wr_dis_i = 0; stat_wr_i = 0; prog_byte_i = 0; prog_auto_i = 0;
    auto_last_i = 0; erase_sec_i = 0; erase_blk_i = 0; erase_all_i = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk_i); s = 1; @(negedge clk_i); clr();
  endtask

  task automatic stat_write(logic [7:0] d);
    @(negedge clk_i); stat_wr_i = 1; stat_data_i = d; @(negedge clk_i); clr();
  endtask

  // measure busy width directly: strobe applied, then count high cycles
  task automatic busy_len(ref logic s, input int exp, input string req);
    int n = 0;
    @(negedge clk_i); s = 1; @(negedge clk_i); clr();
    while (busy_o && n < 100) begin n++; @(negedge clk_i); end
    check(req, 8'(n), 8'(exp));
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1; rst_ni = 0; idle(2);
    check("R1", status_o, 8'h0C);
    check("R1", {5'd0, write_ok_o, busy_o, cmd_dropped_o}, 8'h00);
    rst_ni = 1;
    cur_req = "R4"; pulse(erase_sec_i); pulse(prog_byte_i); idle(3);
    check("R4", {7'd0, busy_o}, 8'h00);
    cur_req = "R2"; pulse(wr_en_i); check("R2", status_o, 8'h0E);
    cur_req = "R5"; busy_len(prog_byte_i, T_PB, "R5");
    check("R6", {7'd0, write_ok_o}, 8'h00);
    cur_req = "R9"; pulse(wr_en_i);
    @(negedge clk_i); erase_sec_i = 1; @(negedge clk_i); clr();
    wr_en_i = 1; @(negedge clk_i); clr(); stat_wr_i = 1; stat_data_i = 8'h80;
    @(negedge clk_i); clr(); idle(1);
    check("R9", status_o & 8'h8C, 8'h0C);
    idle(1); prog_byte_i = 1; @(negedge clk_i); clr();   // final busy cycle
    idle(3);
    cur_req = "R5";
    pulse(wr_en_i); busy_len(erase_blk_i, T_EB, "R5");
    pulse(wr_en_i); busy_len(erase_all_i, T_EA, "R5");
    check("R6", {7'd0, write_ok_o}, 8'h00);
    cur_req = "R8";
    stat_write(8'h73); check("R8", status_o, 8'h00);
    stat_write(8'h8C); check("R8", status_o, 8'h8C);
    stat_write(8'h00); check("R8", status_o, 8'h0C);
    stat_write(8'h04); stat_write(8'hFB); check("R8", status_o, 8'h88);
    stat_write(8'h7F); check("R8", status_o, 8'h08);
    cur_req = "R7";
    pulse(wr_en_i); busy_len(prog_auto_i, T_PA, "R7");
    check("R7", status_o & 8'h42, 8'h42);
    busy_len(prog_auto_i, T_PA, "R7");
    @(negedge clk_i); prog_auto_i = 1; auto_last_i = 1; @(negedge clk_i); clr();
    idle(T_PA + 1);
    check("R7", status_o & 8'h43, 8'h00);
    cur_req = "R3";
    pulse(wr_en_i); pulse(prog_auto_i); idle(T_PA + 1);
    pulse(wr_dis_i); check("R3", status_o & 8'h42, 8'h00);
    cur_req = "R10";
    @(negedge clk_i); wr_en_i = 1; wr_dis_i = 1; @(negedge clk_i); clr();
    check("R10", {7'd0, write_ok_o}, 8'h00);
    pulse(wr_en_i);
    @(negedge clk_i); erase_sec_i = 1; erase_all_i = 1; @(negedge clk_i); clr();
    idle(T_ES);
    check("R10", {7'd0, busy_o}, 8'h01);
    idle(T_EA);
    cur_req = "R1";
    rst_ni = 0; idle(1); check("R1", status_o, 8'h0C);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule